// File: doc/BRIEF.md
# Multi-channel request crossbar scheduler

This block sits between a set of upstream request channels and an equal number of per-chip flash operation engines. Each channel hands in requests that carry the index of the engine they are meant for. Each request waits in a small queue owned by its channel. A central scheduler picks which waiting request may connect next. A request is connected only when its own channel has no live connection and the addressed engine is neither held by another connection nor reporting busy. Once connected, the channel's datapath is steered through an N×N crossbar to the engine, and the engine's return data is steered back. The engine gets a single-cycle start strobe.

Each engine has a link state machine with three states. FREE means no connection. LAUNCH lasts exactly one cycle, and during it the start strobe is driven. HOLD keeps the connection while the engine reports busy. The transitions are FREE→LAUNCH on a grant, LAUNCH→HOLD unconditionally, and HOLD→FREE on the first cycle in which the engine's busy input is low. Its channel is released in that same transition. Conflicts on a channel, on an engine, or on both are settled by arrival order. Every accepted request is stamped from a global sequence counter, and the oldest eligible queue head wins. Several disjoint connections may be live at once. Each crossbar output is a binary tree of 2:1 multiplexers, log2(N) levels deep.

Top module: `chan_xbar_scheduler`

## Requirements
- R1: While reset is asserted, `ctl_start`, `ch_grant`, `ctl_data` and `ch_rdata` are all zero and every `req_ready` bit is 1.
- R2: Channel c accepts a request in a cycle where `req_valid[c]` and `req_ready[c]` are both high. `req_ready[c]` is low exactly when the channel's queue holds Q_DEPTH requests, and a request offered while it is low is dropped. A channel's requests connect in the order it issued them.
- R3: An engine is granted only while its link state is FREE and its `ctl_busy` input is low, so at most one connection reaches an engine at a time.
- R4: A channel with a live connection gets no further connection until that connection is released, even when other engines are free.
- R5: At most one connection is granted per cycle. It goes to the eligible queue head that arrived earliest, and requests that arrived in the same cycle are ordered by lower channel index first.
- R6: A request accepted at clock edge k can be granted at edge k+1 at the earliest. The grant makes `ctl_start` of the engine and `ch_grant` of the channel high together for exactly one cycle, namely the cycle following the grant edge.
- R7: While engine k is connected (LAUNCH or HOLD), `ctl_data[k]` equals `ch_data` of the connected channel, following it combinationally. Otherwise `ctl_data[k]` is zero.
- R8: While channel c is connected, `ch_rdata[c]` equals `ctl_rdata` of the connected engine. Otherwise `ch_rdata[c]` is zero.
- R9: The engine must raise `ctl_busy` no later than the cycle after its start strobe. The connection is released at the first edge in the HOLD state at which `ctl_busy` is low. The freed engine and the freed channel can be granted again at the following edge.
- R10: The engine addressed by a request is the binary value of its LG-bit field `req_dest[c*LG +: LG]`, where LG = log2(N_CH). N_CH must be a power of two, at least 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_CH | Per-channel request offer |
| req_dest | input | N_CH*LG | Per-channel target engine index |
| req_ready | output | N_CH | Per-channel queue has room |
| ch_data | input | N_CH*DATA_W | Per-channel outbound datapath |
| ch_rdata | output | N_CH*DATA_W | Per-channel return datapath |
| ch_grant | output | N_CH | One-cycle pulse: channel's head request connected |
| ctl_data | output | N_CH*DATA_W | Per-engine datapath from its connected channel |
| ctl_rdata | input | N_CH*DATA_W | Per-engine return datapath |
| ctl_start | output | N_CH | One-cycle start strobe per engine |
| ctl_busy | input | N_CH | Per-engine busy indication |

## Verification
The bench builds the block with four channels, an 8-bit datapath and a two-entry queue. With so few entries, a full queue and a dropped offer occur within a handful of cycles. With so few engines, random traffic keeps producing collisions on the same engine, on the same channel, and on both at once. The tie case of two channels arriving in the same cycle and the back-to-back requests of one channel are also driven explicitly. Emulated engines stay busy for random durations, so release and immediate regrant happen at many different phases relative to new arrivals.

// File: rtl/cxs_pkg.sv
package cxs_pkg;

    // Link state of one engine-side crossbar port.
    typedef enum logic [1:0] {
        LK_FREE   = 2'd0,
        LK_LAUNCH = 2'd1,
        LK_HOLD   = 2'd2
    } link_state_e;

endpackage

// File: rtl/cxs_mux_tree.sv
// N:1 selector built as a complete binary tree of 2:1 muxes.
// Heap layout: node i has children 2i+1 and 2i+2; leaves sit at N-1+j.
module cxs_mux_tree #(
    parameter int N  = 8,
    parameter int DW = 24,
    localparam int LG = $clog2(N),
    localparam int NODES = 2 * N - 1
) (
    input  logic [N*DW-1:0] in_flat,
    input  logic [LG-1:0]   sel,
    output logic [DW-1:0]   out
);

    logic [DW-1:0] node [NODES];

    genvar j;
    generate
        for (j = 0; j < N; j++) begin : g_leaf
            assign node[N - 1 + j] = in_flat[j*DW +: DW];
        end
        for (j = 0; j < N - 1; j++) begin : g_inner
            // Depth below the root selects which select bit steers this node.
            localparam int DEPTH = $clog2(j + 2) - 1;
            assign node[j] = sel[LG - 1 - DEPTH] ? node[2*j + 2] : node[2*j + 1];
        end
    endgenerate

    assign out = node[0];

endmodule

// File: rtl/cxs_req_fifo.sv
// Per-channel request queue.
module cxs_req_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         not_empty,
    output logic         not_full
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign not_empty = (count != '0);
    assign not_full  = (count != CW'(DEPTH));
    assign do_push   = push && not_full;
    assign do_pop    = pop && not_empty;
    assign dout      = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // R2: the scheduler never pops an empty queue
    a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> not_empty);
    // R2: occupancy stays within the queue depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

// File: rtl/cxs_sched.sv
// Oldest-first arbiter plus one link state machine per engine.
module cxs_sched
    import cxs_pkg::*;
#(
    parameter int N    = 8,
    parameter int SEQW = 16,
    localparam int LG = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    head_valid,
    input  logic [N*LG-1:0] head_dest,
    input  logic [N*SEQW-1:0] head_stamp,
    input  logic [SEQW-1:0] seq_now,
    input  logic [N-1:0]    ctl_busy,
    output logic [N-1:0]    pop,
    output logic [N-1:0]    ctl_start,
    output logic [N-1:0]    ctl_conn,
    output logic [N*LG-1:0] ctl_owner,
    output logic [N-1:0]    ch_grant,
    output logic [N-1:0]    ch_conn,
    output logic [N*LG-1:0] ch_peer
);

    link_state_e  state_q [N];
    link_state_e  state_d [N];
    logic [LG-1:0] owner_q [N];
    logic [LG-1:0] peer_q  [N];
    logic [N-1:0]  conn_q;
    logic [N-1:0]  grant_q;
    logic [N-1:0]  hit;
    logic [N-1:0]  release_k;

    // ---------------- arbitration ----------------
    logic          found;
    logic [LG-1:0] best_ch;
    logic [LG-1:0] best_dest;
    logic [SEQW-1:0] best_age;
    logic [SEQW-1:0] age_c;
    logic [LG-1:0] dest_c;
    logic          elig_c;

    always_comb begin
        found     = 1'b0;
        best_ch   = '0;
        best_dest = '0;
        best_age  = '0;
        age_c     = '0;
        dest_c    = '0;
        elig_c    = 1'b0;
        for (int c = 0; c < N; c++) begin
            dest_c = head_dest[c*LG +: LG];
            age_c  = seq_now - head_stamp[c*SEQW +: SEQW];
            elig_c = head_valid[c] && !conn_q[c] &&
                     (state_q[dest_c] == LK_FREE) && !ctl_busy[dest_c];
            // strict compare: on equal age the lower channel keeps the grant
            if (elig_c && (!found || age_c > best_age)) begin
                found     = 1'b1;
                best_ch   = LG'(c);
                best_dest = dest_c;
                best_age  = age_c;
            end
        end
    end

    always_comb begin
        pop = '0;
        if (found) pop[best_ch] = 1'b1;
    end

    // ---------------- per-engine link FSM ----------------
    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_link
            assign hit[k]       = found && (best_dest == LG'(k));
            assign release_k[k] = (state_q[k] == LK_HOLD) && !ctl_busy[k];

            always_comb begin
                unique case (state_q[k])
                    LK_FREE:   state_d[k] = hit[k] ? LK_LAUNCH : LK_FREE;
                    LK_LAUNCH: state_d[k] = LK_HOLD;
                    LK_HOLD:   state_d[k] = ctl_busy[k] ? LK_HOLD : LK_FREE;
                    default:   state_d[k] = LK_FREE;
                endcase
            end

            // R6: the strobe lasts one cycle
            a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
                ctl_start[k] |=> !ctl_start[k]);
            // R3: a new connection always begins with a start strobe
            a_r3_conn_starts: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ctl_conn[k]) |-> ctl_start[k]);
            // R9: idle in HOLD tears the connection down at the next edge
            a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
                release_k[k] |=> !ctl_conn[k]);
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) state_q[i] <= LK_FREE;
        end else begin
            for (int i = 0; i < N; i++) state_q[i] <= state_d[i];
        end
    end

    // ownership and channel bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conn_q  <= '0;
            grant_q <= '0;
            for (int i = 0; i < N; i++) begin
                owner_q[i] <= '0;
                peer_q[i]  <= '0;
            end
        end else begin
            grant_q <= pop;
            for (int i = 0; i < N; i++) begin
                if (hit[i]) owner_q[i] <= best_ch;
                if (pop[i]) begin
                    conn_q[i] <= 1'b1;
                    peer_q[i] <= best_dest;
                end else if (conn_q[i] && release_k[peer_q[i]]) begin
                    conn_q[i] <= 1'b0;
                end
            end
        end
    end

    // outputs
    always_comb begin
        for (int i = 0; i < N; i++) begin
            ctl_start[i] = (state_q[i] == LK_LAUNCH);
            ctl_conn[i]  = (state_q[i] != LK_FREE);
            ctl_owner[i*LG +: LG] = owner_q[i];
            ch_peer[i*LG +: LG]   = peer_q[i];
        end
        ch_grant = grant_q;
        ch_conn  = conn_q;
    end

    // R5: at most one launch per cycle
    a_r5_single_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl_start));

    // R4: each connected channel points at an engine that points back to it
    generate
        for (k = 0; k < N; k++) begin : g_chk
            a_r4_peer_match: assert property (@(posedge clk) disable iff (!rst_n)
                ch_conn[k] |-> (ctl_conn[peer_q[k]] && owner_q[peer_q[k]] == LG'(k)));
        end
    endgenerate

endmodule

// File: rtl/chan_xbar_scheduler.sv
module chan_xbar_scheduler #(
    parameter int N_CH    = 8,
    parameter int DATA_W  = 24,
    parameter int Q_DEPTH = 4,
    parameter int SEQ_W   = 16,
    localparam int LG = $clog2(N_CH),
    localparam int QW = LG + SEQ_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CH-1:0]        req_valid,
    input  logic [N_CH*LG-1:0]     req_dest,
    output logic [N_CH-1:0]        req_ready,
    input  logic [N_CH*DATA_W-1:0] ch_data,
    output logic [N_CH*DATA_W-1:0] ch_rdata,
    output logic [N_CH-1:0]        ch_grant,
    output logic [N_CH*DATA_W-1:0] ctl_data,
    input  logic [N_CH*DATA_W-1:0] ctl_rdata,
    output logic [N_CH-1:0]        ctl_start,
    input  logic [N_CH-1:0]        ctl_busy
);

    logic [SEQ_W-1:0]      seq_q;
    logic [N_CH-1:0]       push;
    logic [N_CH-1:0]       pop;
    logic [N_CH-1:0]       head_valid;
    logic [N_CH*LG-1:0]    head_dest;
    logic [N_CH*SEQ_W-1:0] head_stamp;
    logic [N_CH-1:0]       ctl_conn;
    logic [N_CH-1:0]       ch_conn;
    logic [N_CH*LG-1:0]    ctl_owner;
    logic [N_CH*LG-1:0]    ch_peer;
    logic [DATA_W-1:0]     fwd_raw [N_CH];
    logic [DATA_W-1:0]     ret_raw [N_CH];

    assign push = req_valid & req_ready;

    // Global arrival stamp: one value per accepting cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     seq_q <= '0;
        else if (|push) seq_q <= seq_q + SEQ_W'(1);
    end

    genvar c;
    generate
        for (c = 0; c < N_CH; c++) begin : g_ch
            logic [QW-1:0] q_out;

            cxs_req_fifo #(.W(QW), .DEPTH(Q_DEPTH)) u_q (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (push[c]),
                .din       ({req_dest[c*LG +: LG], seq_q}),
                .pop       (pop[c]),
                .dout      (q_out),
                .not_empty (head_valid[c]),
                .not_full  (req_ready[c])
            );
            assign head_dest[c*LG +: LG]        = q_out[QW-1 -: LG];
            assign head_stamp[c*SEQ_W +: SEQ_W] = q_out[SEQ_W-1:0];

            // engine-bound path for engine c
            cxs_mux_tree #(.N(N_CH), .DW(DATA_W)) u_fwd (
                .in_flat (ch_data),
                .sel     (ctl_owner[c*LG +: LG]),
                .out     (fwd_raw[c])
            );
            assign ctl_data[c*DATA_W +: DATA_W] = ctl_conn[c] ? fwd_raw[c] : '0;

            // channel-bound path for channel c
            cxs_mux_tree #(.N(N_CH), .DW(DATA_W)) u_ret (
                .in_flat (ctl_rdata),
                .sel     (ch_peer[c*LG +: LG]),
                .out     (ret_raw[c])
            );
            assign ch_rdata[c*DATA_W +: DATA_W] = ch_conn[c] ? ret_raw[c] : '0;
        end
    endgenerate

    cxs_sched #(.N(N_CH), .SEQW(SEQ_W)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (head_valid),
        .head_dest  (head_dest),
        .head_stamp (head_stamp),
        .seq_now    (seq_q),
        .ctl_busy   (ctl_busy),
        .pop        (pop),
        .ctl_start  (ctl_start),
        .ctl_conn   (ctl_conn),
        .ctl_owner  (ctl_owner),
        .ch_grant   (ch_grant),
        .ch_conn    (ch_conn),
        .ch_peer    (ch_peer)
    );

    // R6: a channel grant coincides with some engine start
    a_r6_grant_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_grant) |-> (|ctl_start));
    // R8: connected channels and connected engines are equal in number
    a_r8_conn_balance: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ch_conn) == $countones(ctl_conn));

endmodule

// File: tb/tb_chan_xbar_scheduler.sv
`timescale 1ns/1ps
module tb_chan_xbar_scheduler;

    localparam int N  = 4;
    localparam int DW = 8;
    localparam int QD = 2;
    localparam int LG = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [N-1:0]      req_valid = '0;
    logic [N*LG-1:0]   req_dest = '0;
    logic [N-1:0]      req_ready;
    logic [N*DW-1:0]   ch_data = '0;
    logic [N*DW-1:0]   ch_rdata;
    logic [N-1:0]      ch_grant;
    logic [N*DW-1:0]   ctl_data;
    logic [N*DW-1:0]   ctl_rdata = '0;
    logic [N-1:0]      ctl_start;
    logic [N-1:0]      ctl_busy = '0;

    chan_xbar_scheduler #(.N_CH(N), .DATA_W(DW), .Q_DEPTH(QD)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_dest(req_dest), .req_ready(req_ready),
        .ch_data(ch_data), .ch_rdata(ch_rdata), .ch_grant(ch_grant),
        .ctl_data(ctl_data), .ctl_rdata(ctl_rdata),
        .ctl_start(ctl_start), .ctl_busy(ctl_busy)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int q_dest  [N][$];
    int q_stamp [N][$];
    int m_state [N];   // 0 free, 1 launch, 2 hold
    int m_owner [N];
    bit m_link  [N];
    int m_peer  [N];
    bit m_grant [N];
    int m_seq;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                q_dest[i].delete(); q_stamp[i].delete();
                m_state[i] = 0; m_owner[i] = 0; m_link[i] = 0;
                m_peer[i] = 0; m_grant[i] = 0;
            end
            m_seq = 0;
        end else begin
            int best; int best_stamp; int pre_cnt [N]; bit any_push;
            best = -1; best_stamp = 0;
            for (int c = 0; c < N; c++) begin
                pre_cnt[c] = q_dest[c].size();
                if (pre_cnt[c] > 0 && !m_link[c] &&
                    m_state[q_dest[c][0]] == 0 && !ctl_busy[q_dest[c][0]]) begin
                    if (best < 0 || q_stamp[c][0] < best_stamp) begin
                        best = c; best_stamp = q_stamp[c][0];
                    end
                end
            end
            for (int c = 0; c < N; c++) m_grant[c] = 0;
            for (int k = 0; k < N; k++) begin
                if (m_state[k] == 1) m_state[k] = 2;
                else if (m_state[k] == 2 && !ctl_busy[k]) begin
                    m_state[k] = 0;
                    m_link[m_owner[k]] = 0;
                end
            end
            if (best >= 0) begin
                int d; d = q_dest[best][0];
                m_state[d] = 1; m_owner[d] = best;
                m_link[best] = 1; m_peer[best] = d; m_grant[best] = 1;
                void'(q_dest[best].pop_front()); void'(q_stamp[best].pop_front());
            end
            any_push = 0;
            for (int c = 0; c < N; c++) begin
                if (req_valid[c] && pre_cnt[c] < QD) begin
                    q_dest[c].push_back(int'(req_dest[c*LG +: LG]));
                    q_stamp[c].push_back(m_seq);
                    any_push = 1;
                end
            end
            if (any_push) m_seq++;
        end
    end

    // ---------------- stimulus, engine emulation, checking ----------------
    int t = 0;
    bit start_seen [N];
    int busy_cnt [N];

    always @(negedge clk) begin
        int s; logic [N-1:0] e_start, e_grant, e_ready;
        logic [N*DW-1:0] e_cdata, e_rdata; int dur;
        s = t - 4;
        if (!finished) begin
            if (t == 2) begin
                chk("R1", "ctl_start in reset", 64'(ctl_start), 64'(0));
                chk("R1", "ch_grant in reset", 64'(ch_grant), 64'(0));
                chk("R1", "ctl_data in reset", 64'(ctl_data), 64'(0));
                chk("R1", "ch_rdata in reset", 64'(ch_rdata), 64'(0));
                chk("R1", "req_ready in reset", 64'(req_ready), 64'hF);
            end
            if (rst_n && s >= 0) begin
                for (int k = 0; k < N; k++) begin
                    e_start[k] = (m_state[k] == 1);
                    e_grant[k] = m_grant[k];
                    e_ready[k] = (q_dest[k].size() < QD);
                    e_cdata[k*DW +: DW] = (m_state[k] != 0) ?
                        ch_data[m_owner[k]*DW +: DW] : '0;
                    e_rdata[k*DW +: DW] = m_link[k] ?
                        ctl_rdata[m_peer[k]*DW +: DW] : '0;
                end
                chk("R6", "ctl_start", 64'(ctl_start), 64'(e_start));
                chk("R5", "ch_grant", 64'(ch_grant), 64'(e_grant));
                chk("R2", "req_ready", 64'(req_ready), 64'(e_ready));
                chk("R7", "ctl_data", 64'(ctl_data), 64'(e_cdata));
                chk("R8", "ch_rdata", 64'(ch_rdata), 64'(e_rdata));
            end
            // hand-derived directed checks
            if (s == 4) begin
                chk("R10", "dest 2 started", 64'(ctl_start), 64'h4);
                chk("R5", "same-cycle tie to channel 0", 64'(ch_grant), 64'h1);
            end
            if (s == 7) chk("R3", "held engine not restarted", 64'(ctl_start), 64'h0);
            if (s == 10) begin
                chk("R3", "second user of engine 2", 64'(ctl_start), 64'h4);
                chk("R9", "regrant after release to channel 1", 64'(ch_grant), 64'h2);
            end
            if (s == 14) begin
                chk("R4", "channel 3 first request", 64'(ch_grant), 64'h8);
                chk("R10", "dest 0 started", 64'(ctl_start), 64'h1);
            end
            if (s == 16) begin
                chk("R7", "engine 0 sees channel 3 data", 64'(ctl_data[0 +: DW]),
                    64'(ch_data[3*DW +: DW]));
                chk("R8", "channel 3 sees engine 0 data", 64'(ch_rdata[3*DW +: DW]),
                    64'(ctl_rdata[0 +: DW]));
            end
            if (s == 17) chk("R4", "channel 3 blocked while linked", 64'(ctl_start), 64'h0);
            if (s == 20) begin
                chk("R4", "channel 3 second request", 64'(ctl_start), 64'h2);
                chk("R9", "channel freed then regranted", 64'(ch_grant), 64'h8);
            end
            if (s == 32) chk("R2", "queue 0 has room", 64'(req_ready[0]), 64'h1);
            if (s == 33) chk("R2", "queue 0 full", 64'(req_ready[0]), 64'h0);

            // engine emulation: busy from the cycle after the strobe
            dur = (s < 40) ? 3 : 1 + int'($urandom % 6);
            for (int k = 0; k < N; k++) begin
                if (!rst_n) begin
                    ctl_busy[k] = 1'b0; busy_cnt[k] = 0; start_seen[k] = 0;
                end else begin
                    if (busy_cnt[k] > 0) begin
                        busy_cnt[k]--;
                        if (busy_cnt[k] == 0) ctl_busy[k] = 1'b0;
                    end
                    if (start_seen[k]) begin
                        ctl_busy[k] = 1'b1; busy_cnt[k] = dur;
                    end
                    start_seen[k] = ctl_start[k];
                end
            end

            // stimulus
            rst_n = (t >= 3);
            ch_data   = N*DW'($urandom);
            ctl_rdata = N*DW'($urandom);
            req_valid = '0;
            req_dest  = '0;
            if (s == 2) begin
                req_valid = 4'b0011; req_dest[0 +: LG] = 2; req_dest[LG +: LG] = 2;
            end
            if (s == 12 || s == 13) begin
                req_valid[3] = 1'b1; req_dest[3*LG +: LG] = (s == 12) ? 2'd0 : 2'd1;
            end
            if (s >= 30 && s <= 33) begin
                req_valid[0] = 1'b1; req_dest[0 +: LG] = 2;
            end
            if (s >= 40 && s < 2900) begin
                for (int c = 0; c < N; c++) begin
                    req_valid[c] = ($urandom % 3 == 0);
                    req_dest[c*LG +: LG] = LG'($urandom);
                end
            end
            t++;
            if (s == 3000) begin
                finished = 1;
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule